// File: doc/BRIEF.md
# Master interrupt routing controller

This block gathers 32 level-sensitive device interrupt lines, records them in a pending register and masks them with a disable register. Each enabled pending line is translated into a processor interrupt level between 1 and 15 through a fixed lookup. Several lines can share one level. The resulting hard levels go to a single CPU, chosen by a programmable target register. Lines that map to level 15 are broadcast to every CPU and are not subject to the per-line disable bits.

Software reaches five word registers over a simple 32-bit bus with a valid and a write-enable strobe. The registers are pending, disable, enable-clear, disable-set and target. Bit 31 of the disable register is a global master disable that blocks every level to every CPU. The output is one 16-bit level vector per CPU, which downstream per-CPU logic merges with its local sources.

Top module: `irq_router`

## Requirements
- R1: At each clock edge the pending register takes the level of `src_i`. Bits 23, 24, 25, 26 and 31 have level 0, so they are never pending. A read of word index 0 returns the pending register.
- R2: After reset the pending register is 0, the target is CPU 0, the disable register is 0xF05DFF80 and every CPU level output is 0. A read of word index 1 returns the disable register ANDed with the valid mask 0xF05DFF80.
- R3: A write to word index 2 clears the disable bits set in (wdata AND 0xF05DFF80). A write to word index 3 sets those bits. Neither write changes the pending register.
- R4: A write to word index 4 keeps the low log2(NCPU) bits of wdata as the target CPU. A read of index 4 returns the target, zero-extended.
- R5: Source bits 0 to 31 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Bit L of the target CPU's 16-bit output (bits [16c+15:16c] of `cpu_level_o` for CPU c) is 1 when at least one pending, non-disabled source maps to level L. Bit 0 of every CPU output is always 0.
- R6: CPUs other than the target receive no levels 1 to 14.
- R7: While any of sources 27 to 30 is pending, bit 15 is set on every CPU output, whatever the per-line disable bits hold.
- R8: While disable bit 31 is 1, every CPU output is all zeros.
- R9: A read has one cycle of latency: `bus_rdata_o` changes at the edge that samples the read, and it holds its value between reads. Indices 5 to 7 read as 0. Writes to indices 0, 1 and 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Device interrupt levels |
| bus_valid_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| cpu_level_o | output | 16*NCPU | Per-CPU level vectors, CPU c at [16c+15:16c] |

## Verification
A change on a source line reaches the pending register and the level outputs at the next clock edge. A register write changes the outputs at the edge that samples it, and read data appears after the edge that samples the read. The bench drives inputs on falling edges. A behavioural model updates its state on rising edges, and the bench compares the model's read data and level vectors with the design on every falling edge. Directed sequences check explicit values one full cycle after each stimulus.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned SRC_W  = 32;
  localparam int unsigned LVL_W  = 16;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned MASTER = 31;
  localparam logic [SRC_W-1:0] DIS_VALID = 32'hF05D_FF80;

  typedef enum logic [IDX_W-1:0] {
    IDX_PEND = 3'd0,
    IDX_DIS  = 3'd1,
    IDX_ENA  = 3'd2,
    IDX_DSET = 3'd3,
    IDX_TGT  = 3'd4
  } reg_idx_e;

  // processor level carried by each source line; 0 means unused
  function automatic logic [3:0] src_level(input int unsigned b);
    case (b)
      0, 7:              src_level = 4'd2;
      1, 8:              src_level = 4'd3;
      2, 9:              src_level = 4'd5;
      3, 10:             src_level = 4'd7;
      4, 11, 21:         src_level = 4'd9;
      5, 12, 22:         src_level = 4'd11;
      6, 13, 17:         src_level = 4'd13;
      14, 15:            src_level = 4'd12;
      16:                src_level = 4'd6;
      18:                src_level = 4'd4;
      19:                src_level = 4'd10;
      20:                src_level = 4'd8;
      27, 28, 29, 30:    src_level = 4'd15;
      default:           src_level = 4'd0;
    endcase
  endfunction

  function automatic logic [SRC_W-1:0] used_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < SRC_W; b++) m[b] = (src_level(b) != 4'd0);
    return m;
  endfunction

  function automatic logic [SRC_W-1:0] top_level_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < SRC_W; b++) m[b] = (src_level(b) == 4'd15);
    return m;
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  localparam int unsigned TW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             bus_valid_i,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_addr_i,
  input  logic [SRC_W-1:0] bus_wdata_i,
  output logic [SRC_W-1:0] bus_rdata_o,
  output logic [SRC_W-1:0] pend_o,
  output logic [SRC_W-1:0] dis_o,
  output logic [TW-1:0]    tgt_o
);

  localparam logic [SRC_W-1:0] USED = used_mask();

  logic [SRC_W-1:0] pend_q, pend_d;
  logic [SRC_W-1:0] dis_q, dis_d;
  logic [TW-1:0]    tgt_q, tgt_d;
  logic [SRC_W-1:0] rd_q, rd_d;
  logic             dis_en, tgt_en, rd_en;
  logic             wr, rd;
  logic [SRC_W-1:0] wmask;

  always_comb begin
    wr     = bus_valid_i && bus_we_i;
    rd     = bus_valid_i && !bus_we_i;
    wmask  = bus_wdata_i & DIS_VALID;
    pend_d = src_i & USED;
    dis_en = 1'b0;
    dis_d  = dis_q;
    tgt_en = 1'b0;
    tgt_d  = bus_wdata_i[TW-1:0];
    if (wr && bus_addr_i == IDX_ENA) begin
      dis_en = 1'b1;
      dis_d  = dis_q & ~wmask;
    end
    if (wr && bus_addr_i == IDX_DSET) begin
      dis_en = 1'b1;
      dis_d  = dis_q | wmask;
    end
    if (wr && bus_addr_i == IDX_TGT) tgt_en = 1'b1;
    rd_en = rd;
    case (bus_addr_i)
      IDX_PEND: rd_d = pend_q;
      IDX_DIS:  rd_d = dis_q & DIS_VALID;
      IDX_TGT:  rd_d = {{(SRC_W-TW){1'b0}}, tgt_q};
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= DIS_VALID;
      tgt_q  <= '0;
      rd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (dis_en) dis_q <= dis_d;
      if (tgt_en) tgt_q <= tgt_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign pend_o      = pend_q;
  assign dis_o       = dis_q;
  assign tgt_o       = tgt_q;
  assign bus_rdata_o = rd_q;

  // R3: disable register moves only on writes to index 2 or 3
  assert_dis_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid_i && bus_we_i && (bus_addr_i == IDX_ENA || bus_addr_i == IDX_DSET))
    |=> $stable(dis_q));

  // R3: a disable-set write leaves every requested valid bit set
  assert_dis_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_we_i && bus_addr_i == IDX_DSET)
    |=> ((dis_q & $past(bus_wdata_i & DIS_VALID)) == $past(bus_wdata_i & DIS_VALID)));

  // R4: target changes only on a write to index 4
  assert_tgt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid_i && bus_we_i && bus_addr_i == IDX_TGT) |=> $stable(tgt_q));

  // R9: read data holds between reads
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid_i && !bus_we_i) |=> $stable(bus_rdata_o));

endmodule

// File: rtl/irq_router_map.sv
module irq_router_map
  import irq_router_pkg::*;
(
  input  logic [SRC_W-1:0] pend_i,
  input  logic [SRC_W-1:0] dis_i,
  output logic [LVL_W-1:0] hard_lvl_o,
  output logic             bcast15_o
);

  localparam logic [SRC_W-1:0] TOP15 = top_level_mask();

  logic [SRC_W-1:0] live;
  logic [LVL_W-1:0] contrib [SRC_W];

  assign live = pend_i & ~dis_i;

  for (genvar s = 0; s < SRC_W; s++) begin : g_src
    localparam logic [3:0] L = src_level(s);
    if (L != 4'd0) begin : g_used
      assign contrib[s] = live[s] ? (LVL_W'(1) << L) : '0;
    end else begin : g_unused
      assign contrib[s] = '0;
    end
  end

  always_comb begin
    hard_lvl_o = '0;
    for (int s = 0; s < SRC_W; s++) hard_lvl_o = hard_lvl_o | contrib[s];
  end

  assign bcast15_o = |(pend_i & TOP15);

  // R5: no source ever produces level 0
  always_comb assert_no_lvl0_R5: assert (hard_lvl_o[0] == 1'b0);

endmodule

// File: rtl/irq_router_route.sv
module irq_router_route
  import irq_router_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  localparam int unsigned TW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      hard_lvl_i,
  input  logic                  bcast15_i,
  input  logic                  master_off_i,
  input  logic [TW-1:0]         tgt_i,
  output logic [NCPU*LVL_W-1:0] cpu_lvl_o
);

  logic [NCPU-1:0] top_bits;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic             is_tgt;
    logic [LVL_W-1:0] lvl;
    assign is_tgt = (tgt_i == TW'(c));
    always_comb begin
      lvl = '0;
      if (!master_off_i) begin
        if (is_tgt) lvl = hard_lvl_i;
        lvl[LVL_W-1] = lvl[LVL_W-1] | bcast15_i;
      end
    end
    assign cpu_lvl_o[c*LVL_W +: LVL_W] = lvl;
    assign top_bits[c] = lvl[LVL_W-1];

    // R6: only the target sees levels 1 to 14
    assert_nontarget_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_tgt |-> (cpu_lvl_o[c*LVL_W+1 +: LVL_W-2] == '0));
  end

  // R7: level 15 is identical on every CPU
  assert_top_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_bits == '0) || (top_bits == '1));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           src_i,
  input  logic                  bus_valid_i,
  input  logic                  bus_we_i,
  input  logic [2:0]            bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic [NCPU*16-1:0]    cpu_level_o
);

  localparam int unsigned TW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [SRC_W-1:0] pend, dis;
  logic [TW-1:0]    tgt;
  logic [LVL_W-1:0] hard_lvl;
  logic             bcast15;

  irq_router_regs #(.NCPU(NCPU)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .pend_o(pend), .dis_o(dis), .tgt_o(tgt)
  );

  irq_router_map u_map (
    .pend_i(pend), .dis_i(dis),
    .hard_lvl_o(hard_lvl), .bcast15_o(bcast15)
  );

  irq_router_route #(.NCPU(NCPU)) u_route (
    .clk(clk), .rst_n(rst_n),
    .hard_lvl_i(hard_lvl), .bcast15_i(bcast15),
    .master_off_i(dis[MASTER]), .tgt_i(tgt),
    .cpu_lvl_o(cpu_level_o)
  );

  // R8: master disable silences every CPU
  assert_master_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis[MASTER] |-> (cpu_level_o == '0));

  // R1: an unused source line never shows as pending
  assert_unused_never_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[31] == 1'b0) && (pend[26:23] == 4'b0));

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

  localparam int NCPU = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VMASK = 32'hF05D_FF80;

  logic              clk, rst_n;
  logic [31:0]       src_i;
  logic              bus_valid_i, bus_we_i;
  logic [2:0]        bus_addr_i;
  logic [31:0]       bus_wdata_i;
  logic [31:0]       bus_rdata_o;
  logic [NCPU*16-1:0] cpu_level_o;

  irq_router #(.NCPU(NCPU)) dut (.*);

  int checks = 0;
  int errors = 0;
  int lvl_tab [32] = '{2,3,5,7,9,11,13,2, 3,5,7,9,11,13,12,12,
                       6,13,4,10,8,9,11,0, 0,0,0,15,15,15,15,0};

  // behavioural model
  logic [31:0] m_pend, m_dis, m_rd;
  int          m_tgt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_dis = VMASK; m_tgt = 0; m_rd = 0;
    end else begin
      if (bus_valid_i && !bus_we_i) begin
        case (bus_addr_i)
          3'd0: m_rd = m_pend;
          3'd1: m_rd = m_dis & VMASK;
          3'd4: m_rd = m_tgt;
          default: m_rd = 0;
        endcase
      end
      if (bus_valid_i && bus_we_i) begin
        if (bus_addr_i == 3'd2) m_dis = m_dis & ~(bus_wdata_i & VMASK);
        if (bus_addr_i == 3'd3) m_dis = m_dis | (bus_wdata_i & VMASK);
        if (bus_addr_i == 3'd4) m_tgt = bus_wdata_i % NCPU;
      end
      m_pend = 0;
      for (int b = 0; b < 32; b++)
        if (src_i[b] && lvl_tab[b] != 0) m_pend[b] = 1'b1;
    end
  end

  function automatic logic [15:0] model_lvl(int c);
    logic [15:0] v;
    v = 0;
    if (!m_dis[31]) begin
      for (int b = 0; b < 32; b++) begin
        if (c == m_tgt && m_pend[b] && !m_dis[b] && lvl_tab[b] != 0) v[lvl_tab[b]] = 1'b1;
        if (m_pend[b] && lvl_tab[b] == 15) v[15] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 read data", bus_rdata_o, m_rd);
      for (int c = 0; c < NCPU; c++)
        check(c == m_tgt ? "R5 target levels" : "R6/R7 other cpu levels",
              {16'h0, cpu_level_o[c*16 +: 16]}, {16'h0, model_lvl(c)});
    end
  end

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1; bus_we_i = 1; bus_addr_i = idx; bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1; bus_we_i = 0; bus_addr_i = idx;
    @(negedge clk);
    bus_valid_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  function automatic logic [15:0] cpu_out(int c);
    return cpu_level_o[c*16 +: 16];
  endfunction

  logic [31:0] r;

  initial begin
    rst_n = 0; src_i = 0; bus_valid_i = 0; bus_we_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset outputs", {{(32-NCPU*16 % 32){1'b0}}, 32'(cpu_level_o != 0)}, 0);
    rd(3'd1, r); check("R2 reset disable", r, 32'hF05D_FF80);
    rd(3'd4, r); check("R2 reset target", r, 0);
    rd(3'd0, r); check("R2 reset pending", r, 0);

    set_src(32'h0000_0001);
    check("R8 master disabled", {16'h0, cpu_out(0)}, 0);
    rd(3'd0, r); check("R1 pending follows source", r, 32'h1);

    wr(3'd2, 32'h8000_0000);
    check("R5 level 2 on target", {16'h0, cpu_out(0)}, 32'h0004);
    check("R6 non-target quiet", {16'h0, cpu_out(1)}, 0);

    set_src(32'h0000_0100);
    check("R3 disabled source blocked", {16'h0, cpu_out(0)}, 0);
    wr(3'd2, 32'h0000_0100);
    check("R3 enable-clear opens source", {16'h0, cpu_out(0)}, 32'h0008);

    wr(3'd4, 32'h0000_0005);
    rd(3'd4, r); check("R4 target low bits", r, 32'h1);
    check("R4 new target receives", {16'h0, cpu_out(1)}, 32'h0008);
    check("R6 old target quiet", {16'h0, cpu_out(0)}, 0);

    set_src(32'h1000_0100);
    check("R7 broadcast cpu0", {16'h0, cpu_out(0)}, 32'h8000);
    check("R7 broadcast cpu1", {16'h0, cpu_out(1)}, 32'h8008);
    check("R7 broadcast cpu3", {16'h0, cpu_out(3)}, 32'h8000);

    set_src(32'h8780_0000);
    rd(3'd0, r); check("R1 unused lines not pending", r, 0);

    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd1, r); check("R3 disable-set valid bits", r, 32'hF05D_FF80);
    set_src(32'h1000_0001);
    check("R8 master disable blocks broadcast", {16'h0, cpu_out(0) | cpu_out(1)}, 0);
    rd(3'd0, r); check("R3 pending untouched by disable writes", r, 32'h1000_0001);

    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'h0000_0000);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd1, r); check("R9 writes to other indices ignored", r, 32'hF05D_FF80);
    rd(3'd5, r); check("R9 unmapped read zero", r, 0);
    rd(3'd4, r); check("R9 target kept", r, 32'h1);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      src_i = (i % 7 == 0) ? $urandom : ($urandom & $urandom);
      bus_valid_i = ($urandom % 3) == 0;
      bus_we_i = $urandom % 2;
      bus_addr_i = $urandom % 8;
      bus_wdata_i = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h7FFF_FFFF);
    end
    @(negedge clk);
    bus_valid_i = 0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule